// File: doc/BRIEF.md
# PWM Operating-Mode Selector

This block holds the operating mode of a PWM stage and steps it forward each time a single select line is pulsed high. The mode sets where the final PWM output comes from: it is held at ground, taken from a DC-mode PWM source, taken from an AC-mode PWM source, or, in a self-test mode, switched between the DC and AC sources on a fixed interval. The select line is meant to be driven by a pushbutton or a slow control line. A new pulse is accepted only after the line has been low for a guard interval, so one press cannot step the mode twice.

A lock output is high while a further step would be refused. This lets a user see when the next press will count. The block also splits an 8-bit control word into the fields that the waveform generators use: a 4-bit duty code, a 6-bit frequency code and a 2-bit modulation-index code. Both intervals are given in clock cycles as parameters. Their defaults are one second and ten seconds at 50 MHz.

Top module: `pwm_mode_selector`

## Requirements
- R1: `mode_o` is 00 after reset. Each accepted select pulse adds one to it, and 11 wraps to 00. The new value is visible after the third rising clock edge that follows `sel_i` going high, because the select line passes through two synchronizer flops.
- R2: A rising level on the synchronized select line is accepted only if the line was low for at least `LOCK_CYC` consecutive cycles since its previous high level. The first rise after reset is accepted. A rejected rise leaves `mode_o` unchanged.
- R3: `lock_o` is low after reset. It is high from the cycle after the synchronized select line goes high until `LOCK_CYC` consecutive low cycles have passed.
- R4: In mode 00, `pwm_o` is 0 whatever the PWM inputs are.
- R5: In mode 01, `pwm_o` equals `dc_pwm_i`.
- R6: In mode 10, `pwm_o` equals `ac_pwm_i`.
- R7: In mode 11, `pwm_o` follows `dc_pwm_i` for the first `TEST_CYC` cycles after entry, then `ac_pwm_i` for `TEST_CYC` cycles, and keeps alternating.
- R8: Leaving mode 11 clears the self-test phase, even when the step lands on a swap cycle. The next entry into mode 11 starts on the DC source.
- R9: In every mode, `duty_o` = `ctrl_i[3:0]`, `freq_o` = `ctrl_i[5:0]` and `index_o` = `ctrl_i[7:6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Asynchronous mode-step select line |
| ctrl_i | input | 8 | Control word for the duty, frequency and index fields |
| dc_pwm_i | input | 1 | DC-mode PWM source |
| ac_pwm_i | input | 1 | AC-mode PWM source |
| pwm_o | output | 1 | Selected PWM output |
| duty_o | output | 4 | Duty code, `ctrl_i[3:0]` |
| freq_o | output | 6 | Frequency code, `ctrl_i[5:0]` |
| index_o | output | 2 | Modulation-index code, `ctrl_i[7:6]` |
| mode_o | output | 2 | Current mode: 00 ground, 01 DC, 10 AC, 11 self-test |
| lock_o | output | 1 | High while a new select pulse would be refused |

## Verification
Two functions can act on the same clock edge: an accepted select pulse that moves the mode out of 11, and the self-test timer swapping sources. The bench sweeps the arrival of the leaving pulse over seven offsets centred on the swap edge, so the mode step lands a few cycles before, on, and after the swap. In each case it expects mode 00 with a grounded output while both sources are held high. It then steps back into mode 11 and expects the DC source for the first interval, which shows that no self-test phase was carried over from the collision.

// File: rtl/mode_sel_pkg.sv
package mode_sel_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_DC   = 2'b01,
        MODE_AC   = 2'b10,
        MODE_TEST = 2'b11
    } op_mode_e;
endpackage

// File: rtl/sel_sync.sv
module sel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lockout_gate.sv
module lockout_gate #(
    parameter int LOCK_CYC = 50_000_000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sel_s_i,
    output logic step_o,
    output logic lock_o
);
    localparam int CW = (LOCK_CYC > 2) ? $clog2(LOCK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

    typedef struct packed {
        logic          prev;
        logic          armed;
        logic [CW-1:0] cnt;
    } gate_t;

    gate_t s_d, s_q;
    logic  rise;

    always_comb begin
        s_d      = s_q;
        s_d.prev = sel_s_i;
        rise     = sel_s_i && !s_q.prev;
        if (sel_s_i) begin
            s_d.armed = 1'b0;
            s_d.cnt   = '0;
        end else if (!s_q.armed) begin
            if (s_q.cnt == LAST) begin
                s_d.armed = 1'b1;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.prev  <= 1'b0;
            s_q.armed <= 1'b1;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign step_o = rise && s_q.armed;
    assign lock_o = !s_q.armed;
endmodule

// File: rtl/mode_core.sv
module mode_core
    import mode_sel_pkg::*;
#(
    parameter int TEST_CYC = 500_000_000
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     step_i,
    output op_mode_e mode_o,
    output logic     use_ac_o
);
    localparam int TW = (TEST_CYC > 2) ? $clog2(TEST_CYC) : 1;
    localparam logic [TW-1:0] TLAST = TW'(TEST_CYC - 1);

    typedef struct packed {
        op_mode_e      mode;
        logic          use_ac;
        logic [TW-1:0] timer;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (c_q.mode == MODE_TEST) begin
            if (c_q.timer == TLAST) begin
                c_d.timer  = '0;
                c_d.use_ac = !c_q.use_ac;
            end else begin
                c_d.timer = c_q.timer + 1'b1;
            end
        end else begin
            c_d.timer  = '0;
            c_d.use_ac = 1'b0;
        end
        if (step_i) begin
            c_d.mode = op_mode_e'(c_q.mode + 2'd1);
            if (c_q.mode == MODE_TEST) begin
                c_d.timer  = '0;
                c_d.use_ac = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            c_q.mode   <= MODE_IDLE;
            c_q.use_ac <= 1'b0;
            c_q.timer  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mode_o   = c_q.mode;
    assign use_ac_o = c_q.use_ac;
endmodule

// File: rtl/pwm_route.sv
module pwm_route
    import mode_sel_pkg::*;
(
    input  op_mode_e mode_i,
    input  logic     use_ac_i,
    input  logic     dc_i,
    input  logic     ac_i,
    output logic     pwm_o
);
    always_comb begin
        unique case (mode_i)
            MODE_IDLE: pwm_o = 1'b0;
            MODE_DC:   pwm_o = dc_i;
            MODE_AC:   pwm_o = ac_i;
            MODE_TEST: pwm_o = use_ac_i ? ac_i : dc_i;
            default:   pwm_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_mode_selector.sv
module pwm_mode_selector
    import mode_sel_pkg::*;
#(
    parameter int LOCK_CYC = 50_000_000,
    parameter int TEST_CYC = 500_000_000,
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_W = 8,
    parameter int DUTY_W = 4,
    parameter int FREQ_W = 6,
    parameter int IDX_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sel_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              dc_pwm_i,
    input  logic              ac_pwm_i,
    output logic              pwm_o,
    output logic [DUTY_W-1:0] duty_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic [IDX_W-1:0]  index_o,
    output logic [1:0]        mode_o,
    output logic              lock_o
);
    logic     sel_s;
    logic     step;
    op_mode_e mode;
    logic     use_ac;

    sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_i(rst_i), .async_i(sel_i), .sync_o(sel_s)
    );

    lockout_gate #(.LOCK_CYC(LOCK_CYC)) u_gate (
        .clk_i(clk_i), .rst_i(rst_i), .sel_s_i(sel_s),
        .step_o(step), .lock_o(lock_o)
    );

    mode_core #(.TEST_CYC(TEST_CYC)) u_core (
        .clk_i(clk_i), .rst_i(rst_i), .step_i(step),
        .mode_o(mode), .use_ac_o(use_ac)
    );

    pwm_route u_route (
        .mode_i(mode), .use_ac_i(use_ac),
        .dc_i(dc_pwm_i), .ac_i(ac_pwm_i), .pwm_o(pwm_o)
    );

    assign mode_o  = mode;
    assign duty_o  = ctrl_i[DUTY_W-1:0];
    assign freq_o  = ctrl_i[FREQ_W-1:0];
    assign index_o = ctrl_i[CTRL_W-1 -: IDX_W];
endmodule

// File: rtl/pwm_mode_selector_chk.sv
module pwm_mode_selector_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       dc_pwm_i,
    input logic       ac_pwm_i,
    input logic       pwm_o,
    input logic [1:0] mode_o,
    input logic       lock_o
);
    // R1: every mode change is a step of exactly one
    a_r1_step_one: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(mode_o) |-> mode_o == $past(mode_o) + 2'd1);

    // R2: a mode change needs the lock to have been open
    a_r2_needs_open: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(mode_o) |-> !$past(lock_o));

    // R3: the lock closes together with an accepted step
    a_r3_lock_after_step: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(mode_o) |-> lock_o);

    a_r4_idle_ground: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_o == 2'b00 |-> !pwm_o);

    a_r5_dc_pass: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_o == 2'b01 |-> pwm_o == dc_pwm_i);

    a_r6_ac_pass: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_o == 2'b10 |-> pwm_o == ac_pwm_i);

    // R7: self-test output always comes from one of the two sources
    a_r7_test_source: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_o == 2'b11 |-> (pwm_o == dc_pwm_i || pwm_o == ac_pwm_i));
endmodule

bind pwm_mode_selector pwm_mode_selector_chk u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .dc_pwm_i(dc_pwm_i), .ac_pwm_i(ac_pwm_i),
    .pwm_o(pwm_o), .mode_o(mode_o), .lock_o(lock_o)
);

// File: tb/pwm_mode_selector_tb.sv
module pwm_mode_selector_tb;
    localparam int LOCK = 20;
    localparam int TEST = 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic [7:0] ctrl = '0;
    logic       dc = 1'b0, ac = 1'b0;
    logic       pwm, lock;
    logic [3:0] duty;
    logic [5:0] freq;
    logic [1:0] idx, mode;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_mode_selector #(.LOCK_CYC(LOCK), .TEST_CYC(TEST)) u_dut (
        .clk_i(clk), .rst_i(rst), .sel_i(sel), .ctrl_i(ctrl),
        .dc_pwm_i(dc), .ac_pwm_i(ac), .pwm_o(pwm), .duty_o(duty),
        .freq_o(freq), .index_o(idx), .mode_o(mode), .lock_o(lock)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // raise select at a negedge, hold 3 cycles; returns at the negedge right
    // after the edge where an accepted step becomes visible
    task automatic pulse_rise();
        sel = 1'b1;
        repeat (3) @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic gap();
        repeat (LOCK + 5) @(negedge clk);
    endtask

    task automatic step_ok();
        pulse_rise();
        gap();
    endtask

    task automatic check_src(input string req, input int m);
        for (int k = 0; k < 4; k++) begin
            dc = k[0]; ac = k[1];
            #1;
            chk(req, pwm, (m == 0) ? 0 : (m == 1) ? k[0] : k[1]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        dc = 1; ac = 1;
        chk("R1 reset mode", mode, 0);
        chk("R3 reset lock", lock, 0);
        chk("R4 reset ground", pwm, 0);
        check_src("R4", 0);

        for (int v = 0; v < 256; v++) begin
            ctrl = v[7:0]; #1;
            chk("R9 duty", duty, v % 16);
            chk("R9 freq", freq, v % 64);
            chk("R9 index", idx, v / 64);
        end

        // R1 latency: step visible only after the third edge
        sel = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 not yet", mode, 0);
        @(negedge clk);
        sel = 1'b0;
        chk("R1 first step", mode, 1);
        chk("R3 lock high", lock, 1);
        check_src("R5", 1);

        // R2: a rise after a short low is refused
        repeat (5) @(negedge clk);
        pulse_rise();
        repeat (2) @(negedge clk);
        chk("R2 refused", mode, 1);
        chk("R3 lock still", lock, 1);
        repeat (LOCK - 5) @(negedge clk);
        chk("R3 lock held short of interval", lock, 1);
        repeat (10) @(negedge clk);
        chk("R3 lock released", lock, 0);

        step_ok();
        chk("R1 step to 10", mode, 2);
        check_src("R6", 2);
        for (int v = 0; v < 256; v += 37) begin
            ctrl = v[7:0]; #1;
            chk("R9 duty ac", duty, v % 16);
            chk("R9 index ac", idx, v / 64);
        end

        // R7 self-test alternation
        dc = 1; ac = 0;
        pulse_rise();
        chk("R1 step to 11", mode, 3);
        repeat (TEST - 2) @(negedge clk);
        chk("R7 dc phase", pwm, 1);
        repeat (4) @(negedge clk);
        chk("R7 ac phase", pwm, 0);
        repeat (TEST) @(negedge clk);
        chk("R7 back to dc", pwm, 1);
        step_ok();
        chk("R1 wrap", mode, 0);

        // R8: leaving step swept across the swap edge
        for (int off = -3; off <= 3; off++) begin
            step_ok(); step_ok();
            pulse_rise();
            chk("R8 in test", mode, 3);
            repeat (TEST + off - 3) @(negedge clk);
            dc = 1; ac = 1;
            pulse_rise();
            chk("R8 left test", mode, 0);
            chk("R8 ground", pwm, 0);
            gap();
            dc = 1; ac = 0;
            step_ok(); step_ok();
            pulse_rise();
            chk("R8 reentry mode", mode, 3);
            repeat (TEST - 2) @(negedge clk);
            chk("R8 reentry starts dc", pwm, 1);
            gap();
            step_ok();
            chk("R8 back to idle", mode, 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule